// File: doc/BRIEF.md
# Flash Suspend-Aware Status Logic

This block is the status-keeping core on the device side of a serial NOR flash. A front end that has already shifted in and decoded each chip-select frame hands it one opcode per frame. Each opcode comes with a frame-complete strobe, a sector index and a page index. The block decides whether the command is taken or dropped. It tracks four status flags: the write-enable latch, the busy flag, the program-suspended flag and the erase-suspended flag. It presents these flags as two status bytes.

Programming and erasing are modelled as cycle counters, one for each kind of operation. A counter stops while its operation is suspended and carries on from where it stopped after a resume. The suspend rules set the write-enable latch in different ways for the two operations:

- Suspending an erase drops the latch, so a program inside the suspended erase needs a fresh write enable.
- Resuming an erase sets the latch again without a write enable.
- Suspending a program leaves the latch set.

Reads are checked only for permission against the suspended page and the suspended sector.

Top module: `flash_susp_status`

## Requirements
- R1: After reset, both status bytes read 00h and the acknowledge output is 0.
- R2: Opcode 06h is taken only while no operation is running (status 1 bit 0 clear), and it sets the write-enable latch (status 1 bit 1).
- R3: Page program 02h and sector erase D8h are taken only when all of these hold: the latch is 1, nothing is running and the program-suspended flag (status 2 bit 0) is clear. Sector erase additionally needs the erase-suspended flag (status 2 bit 1) clear. A command that fails these conditions leaves both status bytes unchanged.
- R4: An accepted operation holds status 1 bit 0 high for exactly PROG_CYCLES (program) or ERASE_CYCLES (erase) running cycles. Its completion clears the busy bit, the latch and that operation's suspend flag.
- R5: Program suspend 85h is taken only while a program runs. It clears status 1 bit 0, sets status 2 bit 0 and keeps the latch at 1.
- R6: Program resume 8Ah is taken when status 2 bit 0 is set and nothing runs, with no write enable needed. It sets status 1 bit 0 again and the program finishes after its remaining cycles.
- R7: Erase suspend 75h is taken only while an erase runs. It clears status 1 bit 0, sets status 2 bit 1 and clears the latch.
- R8: While an erase is suspended, a page program to another sector is taken after a new 06h. A program to the suspended sector is dropped. When the inner program completes, the latch is 0 and status 2 bit 1 stays set.
- R9: Erase resume 7Ah is taken when status 2 bit 1 is set, status 2 bit 0 is clear and nothing runs. It needs no write enable and sets both the latch and the busy bit.
- R10: Read 03h is acknowledged only when three conditions hold: nothing runs, the page is not the suspended program page (while status 2 bit 0 is set) and the sector is not the suspended erase sector (while status 2 bit 1 is set).
- R11: A frame that arrives in the same cycle as an operation's completion is dropped, and so is any opcode outside the eight listed.
- R12: The acknowledge output is high for exactly one cycle, in the cycle after the frame strobe of an accepted command, and stays low for a dropped one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | One-cycle strobe: a decoded frame is present |
| op_i | input | 8 | Decoded opcode of the frame |
| sect_i | input | SECT_W | Target sector index |
| page_i | input | PAGE_W | Target page index |
| sr1_o | output | 8 | Status byte 1: bit 0 busy, bit 1 write-enable latch |
| sr2_o | output | 8 | Status byte 2: bit 0 program suspended, bit 1 erase suspended |
| ack_o | output | 1 | Pulse: the previous frame was accepted |

## Verification
The hardest situation to reach from the ports is a frame that lands in the very cycle a busy counter expires. The bench gets there by counting cycles from the acknowledge of the program command and placing a suspend strobe in the last busy cycle. A second hard state is a program that is itself suspended inside an erase suspend, with both suspend flags set. The bench reaches it with a scripted erase, erase-suspend, write-enable, program, program-suspend chain. From there it probes that erase resume is refused and program resume is allowed. A behavioural model in the bench is compared with the status bytes and the acknowledge output on every cycle.

// File: rtl/flash_susp_pkg.sv
package flash_susp_pkg;
  typedef enum logic [1:0] {
    RUN_NONE  = 2'd0,
    RUN_PROG  = 2'd1,
    RUN_ERASE = 2'd2
  } run_e;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_ERASE  = 8'hD8;
  localparam logic [7:0] OP_PSUSP  = 8'h85;
  localparam logic [7:0] OP_PRES   = 8'h8A;
  localparam logic [7:0] OP_ESUSP  = 8'h75;
  localparam logic [7:0] OP_ERES   = 8'h7A;
  localparam logic [7:0] OP_READ   = 8'h03;
endpackage

// File: rtl/susp_busy_timer.sv
module susp_busy_timer #(
  parameter int LEN = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = CW'(LEN);
    end else if (run_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i || run_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = run_i && (cnt_q == CW'(1));

  // R6
  load_not_running_chk : assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !run_i);
endmodule

// File: rtl/susp_cmd_ctrl.sv
module susp_cmd_ctrl
  import flash_susp_pkg::*;
#(
  parameter int SECT_W = 4,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_i,
  input  logic [7:0]        op_i,
  input  logic [SECT_W-1:0] sect_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              pdone_i,
  input  logic              edone_i,
  output logic              pload_o,
  output logic              prun_o,
  output logic              eload_o,
  output logic              erun_o,
  output logic              wel_o,
  output logic              wip_o,
  output logic              ps_o,
  output logic              es_o,
  output logic              ack_o
);
  run_e              run_q, run_d;
  logic              wel_q, wel_d;
  logic              ps_q, ps_d;
  logic              es_q, es_d;
  logic              ack_q, ack_d;
  logic [PAGE_W-1:0] cpage_q, cpage_d;
  logic [PAGE_W-1:0] spage_q, spage_d;
  logic [SECT_W-1:0] csect_q, csect_d;
  logic [SECT_W-1:0] ssect_q, ssect_d;

  logic idle, page_hit, sect_hit;

  assign idle     = (run_q == RUN_NONE);
  assign page_hit = ps_q && (page_i == spage_q);
  assign sect_hit = es_q && (sect_i == ssect_q);

  always_comb begin
    run_d   = run_q;
    wel_d   = wel_q;
    ps_d    = ps_q;
    es_d    = es_q;
    cpage_d = cpage_q;
    spage_d = spage_q;
    csect_d = csect_q;
    ssect_d = ssect_q;
    ack_d   = 1'b0;
    pload_o = 1'b0;
    eload_o = 1'b0;
    if (pdone_i) begin
      run_d = RUN_NONE;
      wel_d = 1'b0;
      ps_d  = 1'b0;
    end else if (edone_i) begin
      run_d = RUN_NONE;
      wel_d = 1'b0;
      es_d  = 1'b0;
    end else if (frame_i) begin
      case (op_i)
        OP_WREN: if (idle) begin
          wel_d = 1'b1;
          ack_d = 1'b1;
        end
        OP_PROG: if (wel_q && idle && !ps_q && !sect_hit) begin
          run_d   = RUN_PROG;
          pload_o = 1'b1;
          cpage_d = page_i;
          ack_d   = 1'b1;
        end
        OP_ERASE: if (wel_q && idle && !ps_q && !es_q) begin
          run_d   = RUN_ERASE;
          eload_o = 1'b1;
          csect_d = sect_i;
          ack_d   = 1'b1;
        end
        OP_PSUSP: if (run_q == RUN_PROG) begin
          run_d   = RUN_NONE;
          ps_d    = 1'b1;
          spage_d = cpage_q;
          ack_d   = 1'b1;
        end
        OP_PRES: if (ps_q && idle) begin
          run_d = RUN_PROG;
          ack_d = 1'b1;
        end
        OP_ESUSP: if (run_q == RUN_ERASE) begin
          run_d   = RUN_NONE;
          es_d    = 1'b1;
          wel_d   = 1'b0;
          ssect_d = csect_q;
          ack_d   = 1'b1;
        end
        OP_ERES: if (es_q && !ps_q && idle) begin
          run_d = RUN_ERASE;
          wel_d = 1'b1;
          ack_d = 1'b1;
        end
        OP_READ: if (idle && !page_hit && !sect_hit) begin
          ack_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= RUN_NONE;
      wel_q   <= 1'b0;
      ps_q    <= 1'b0;
      es_q    <= 1'b0;
      ack_q   <= 1'b0;
      cpage_q <= '0;
      spage_q <= '0;
      csect_q <= '0;
      ssect_q <= '0;
    end else begin
      run_q   <= run_d;
      wel_q   <= wel_d;
      ps_q    <= ps_d;
      es_q    <= es_d;
      ack_q   <= ack_d;
      cpage_q <= cpage_d;
      spage_q <= spage_d;
      csect_q <= csect_d;
      ssect_q <= ssect_d;
    end
  end

  assign prun_o = (run_q == RUN_PROG);
  assign erun_o = (run_q == RUN_ERASE);
  assign wel_o  = wel_q;
  assign wip_o  = !idle;
  assign ps_o   = ps_q;
  assign es_o   = es_q;
  assign ack_o  = ack_q;

  // R4
  wip_needs_wel_chk : assert property (@(posedge clk) disable iff (!rst_n)
    wip_o |-> wel_q);

  // R3
  prog_without_wel_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i && (op_i == OP_PROG) && !wel_q) |=> !ack_q);

  // R5
  psusp_keeps_wel_chk : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps_q) |-> (wel_q && idle));

  // R7
  esusp_drops_wel_chk : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(es_q) |-> !wel_q);

  // R9
  eres_blocked_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i && (op_i == OP_ERES) && ps_q) |=> !ack_q);
endmodule

// File: rtl/flash_susp_status.sv
module flash_susp_status #(
  parameter int SECT_W      = 4,
  parameter int PAGE_W      = 8,
  parameter int PROG_CYCLES = 12,
  parameter int ERASE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_i,
  input  logic [7:0]        op_i,
  input  logic [SECT_W-1:0] sect_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [7:0]        sr1_o,
  output logic [7:0]        sr2_o,
  output logic              ack_o
);
  logic pload, prun, pdone;
  logic eload, erun, edone;
  logic wel, wip, ps, es;

  susp_cmd_ctrl #(.SECT_W(SECT_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_i (frame_i),
    .op_i    (op_i),
    .sect_i  (sect_i),
    .page_i  (page_i),
    .pdone_i (pdone),
    .edone_i (edone),
    .pload_o (pload),
    .prun_o  (prun),
    .eload_o (eload),
    .erun_o  (erun),
    .wel_o   (wel),
    .wip_o   (wip),
    .ps_o    (ps),
    .es_o    (es),
    .ack_o   (ack_o)
  );

  susp_busy_timer #(.LEN(PROG_CYCLES)) u_ptmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (pload),
    .run_i  (prun),
    .done_o (pdone)
  );

  susp_busy_timer #(.LEN(ERASE_CYCLES)) u_etmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (eload),
    .run_i  (erun),
    .done_o (edone)
  );

  assign sr1_o = {6'b0, wel, wip};
  assign sr2_o = {6'b0, es, ps};
endmodule

// File: tb/sim_flash_susp_status.sv
module sim_flash_susp_status;
  localparam int PC = 12;
  localparam int EC = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fd = 1'b0;
  logic [7:0] op = 8'h00;
  logic [3:0] sect = 4'd0;
  logic [7:0] page = 8'd0;
  logic [7:0] sr1, sr2;
  logic       ack;

  int n_cmp = 0;
  int n_bad = 0;
  bit fin = 1'b0;
  bit cmp_en = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk;

  flash_susp_status #(.SECT_W(4), .PAGE_W(8), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_i(fd), .op_i(op), .sect_i(sect),
    .page_i(page), .sr1_o(sr1), .sr2_o(sr2), .ack_o(ack));

  // behavioural reference: run 0 none, 1 program, 2 erase
  int m_run, m_wel, m_ps, m_es, m_ack, m_pcnt, m_ecnt;
  int m_cpage, m_spage, m_csect, m_ssect;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_wel = 0; m_ps = 0; m_es = 0; m_ack = 0;
      m_pcnt = 0; m_ecnt = 0; m_cpage = 0; m_spage = 0; m_csect = 0; m_ssect = 0;
    end else begin
      bit pd, ed, idle, shit, phit;
      pd = (m_run == 1) && (m_pcnt == 1);
      ed = (m_run == 2) && (m_ecnt == 1);
      idle = (m_run == 0);
      shit = (m_es != 0) && (int'(sect) == m_ssect);
      phit = (m_ps != 0) && (int'(page) == m_spage);
      m_ack = 0;
      if (m_run == 1) m_pcnt--;
      if (m_run == 2) m_ecnt--;
      if (pd) begin m_run = 0; m_wel = 0; m_ps = 0; end
      else if (ed) begin m_run = 0; m_wel = 0; m_es = 0; end
      else if (fd) begin
        case (op)
          8'h06: if (idle) begin m_wel = 1; m_ack = 1; end
          8'h02: if (m_wel != 0 && idle && m_ps == 0 && !shit) begin
            m_run = 1; m_pcnt = PC; m_cpage = int'(page); m_ack = 1; end
          8'hD8: if (m_wel != 0 && idle && m_ps == 0 && m_es == 0) begin
            m_run = 2; m_ecnt = EC; m_csect = int'(sect); m_ack = 1; end
          8'h85: if (m_run == 1) begin m_run = 0; m_ps = 1; m_spage = m_cpage; m_ack = 1; end
          8'h8A: if (m_ps != 0 && idle) begin m_run = 1; m_ack = 1; end
          8'h75: if (m_run == 2) begin
            m_run = 0; m_es = 1; m_wel = 0; m_ssect = m_csect; m_ack = 1; end
          8'h7A: if (m_es != 0 && m_ps == 0 && idle) begin m_run = 2; m_wel = 1; m_ack = 1; end
          8'h03: if (idle && !phit && !shit) m_ack = 1;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      logic [7:0] e1, e2;
      e1 = {6'b0, m_wel[0], (m_run != 0)};
      e2 = {6'b0, m_es[0], m_ps[0]};
      n_cmp++;
      if (sr1 !== e1 || sr2 !== e2 || ack !== m_ack[0]) begin
        n_bad++;
        $display("FAIL %s model: sr1 %h/%h sr2 %h/%h ack %b/%b (actual/expected)",
                 tag, sr1, e1, sr2, e2, ack, m_ack[0]);
      end
    end
  end

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] o, input logic [3:0] s, input logic [7:0] p);
    @(negedge clk);
    fd = 1'b1; op = o; sect = s; page = p;
    @(negedge clk);
    fd = 1'b0;
  endtask

  task automatic idle_wait();
    for (int i = 0; i < 200 && sr1[0]; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);
    tag = "R1";
    chk("R1 sr1", sr1, 8'h00); chk("R1 sr2", sr2, 8'h00); chk("R1 ack", {7'b0, ack}, 8'h00);

    tag = "R3"; send(8'h02, 4'd1, 8'd5);
    chk("R3 prog w/o wel", sr1, 8'h00); chk("R3 ack", {7'b0, ack}, 8'h00);
    tag = "R2"; send(8'h06, 4'd0, 8'd0);
    chk("R2 wren", sr1, 8'h02);
    tag = "R12"; chk("R12 ack high", {7'b0, ack}, 8'h01);
    @(negedge clk); chk("R12 ack one cycle", {7'b0, ack}, 8'h00);

    tag = "R4"; send(8'h02, 4'd1, 8'd5);
    n = 0;
    while (sr1[0] && n < 200) begin
      n++;
      if (n == 2) begin tag = "R10"; end
      @(negedge clk);
    end
    chk("R4 prog busy length", 8'(n), 8'(PC));
    chk("R4 done clears", sr1, 8'h00);

    tag = "R5"; send(8'h85, 4'd0, 8'd0);
    chk("R5 psusp idle ignored", sr2, 8'h00);
    tag = "R10"; send(8'h03, 4'd1, 8'd5); chk("R10 idle read", {7'b0, ack}, 8'h01);

    tag = "R5"; send(8'h06, 4'd0, 8'd0); send(8'h02, 4'd2, 8'd7);
    send(8'h03, 4'd2, 8'd1); chk("R10 read busy", {7'b0, ack}, 8'h00);
    repeat (3) @(negedge clk);
    send(8'h85, 4'd0, 8'd0);
    chk("R5 psusp sr1", sr1, 8'h02); chk("R5 psusp sr2", sr2, 8'h01);
    tag = "R3"; send(8'hD8, 4'd3, 8'd0); chk("R3 erase in psusp", sr1, 8'h02);
    tag = "R10"; send(8'h03, 4'd2, 8'd7); chk("R10 susp page", {7'b0, ack}, 8'h00);
    send(8'h03, 4'd2, 8'd8); chk("R10 other page", {7'b0, ack}, 8'h01);
    tag = "R6"; send(8'h8A, 4'd0, 8'd0); chk("R6 resume", sr1, 8'h03);
    idle_wait(); chk("R6 finished sr1", sr1, 8'h00); chk("R4 ps cleared", sr2, 8'h00);

    tag = "R7"; send(8'h06, 4'd0, 8'd0); send(8'hD8, 4'd3, 8'd0);
    repeat (5) @(negedge clk);
    send(8'h75, 4'd0, 8'd0);
    chk("R7 esusp sr1", sr1, 8'h00); chk("R7 esusp sr2", sr2, 8'h02);
    tag = "R8"; send(8'h02, 4'd4, 8'd9); chk("R8 no wren", sr1, 8'h00);
    send(8'h06, 4'd0, 8'd0);
    send(8'h02, 4'd3, 8'd9); chk("R8 same sector", sr1, 8'h02);
    send(8'h02, 4'd4, 8'd9); chk("R8 other sector", sr1, 8'h03);
    tag = "R9"; send(8'h7A, 4'd0, 8'd0); chk("R9 eres while busy", {7'b0, ack}, 8'h00);
    idle_wait();
    tag = "R8"; chk("R8 inner done sr1", sr1, 8'h00); chk("R8 inner done sr2", sr2, 8'h02);
    tag = "R10"; send(8'h03, 4'd3, 8'd0); chk("R10 susp sector", {7'b0, ack}, 8'h00);
    send(8'h03, 4'd5, 8'd0); chk("R10 other sector", {7'b0, ack}, 8'h01);
    tag = "R9"; send(8'h7A, 4'd0, 8'd0);
    chk("R9 eres sr1", sr1, 8'h03); chk("R9 eres sr2", sr2, 8'h02);
    repeat (3) @(negedge clk);
    send(8'h75, 4'd0, 8'd0); chk("R7 second esusp", sr1, 8'h00);
    send(8'h7A, 4'd0, 8'd0); chk("R9 second eres", sr1, 8'h03);
    tag = "R4"; idle_wait();
    chk("R4 erase done sr1", sr1, 8'h00); chk("R4 erase done sr2", sr2, 8'h00);

    tag = "R9"; send(8'h06, 4'd0, 8'd0); send(8'hD8, 4'd1, 8'd0);
    send(8'h75, 4'd0, 8'd0); send(8'h06, 4'd0, 8'd0); send(8'h02, 4'd2, 8'd3);
    send(8'h85, 4'd0, 8'd0); chk("R5 nested psusp sr2", sr2, 8'h03);
    send(8'h7A, 4'd0, 8'd0); chk("R9 eres with ps", sr1, 8'h02);
    tag = "R6"; send(8'h8A, 4'd0, 8'd0); chk("R6 nested resume", sr1, 8'h03);
    idle_wait(); chk("R6 nested done sr2", sr2, 8'h02);
    tag = "R9"; send(8'h7A, 4'd0, 8'd0); chk("R9 eres after nest", sr1, 8'h03);
    idle_wait();

    tag = "R11"; send(8'h06, 4'd0, 8'd0); send(8'h02, 4'd6, 8'd1);
    repeat (PC - 2) @(negedge clk);
    send(8'h85, 4'd0, 8'd0);
    chk("R11 frame on done sr2", sr2, 8'h00); chk("R11 frame on done sr1", sr1, 8'h00);
    chk("R11 frame on done ack", {7'b0, ack}, 8'h00);
    send(8'h06, 4'd0, 8'd0); send(8'hAB, 4'd0, 8'd0);
    chk("R11 unknown opcode ack", {7'b0, ack}, 8'h00); chk("R11 unknown sr1", sr1, 8'h02);

    repeat (2) @(negedge clk);
    fin = 1'b1;
    summary();
    $finish;
  end
endmodule